// File: doc/BRIEF.md
# Digital Down-Converter Decimation Chain

This block pulls one channel out of a stream of real converter samples and hands it on as complex baseband at a lower rate. A phase-accumulating local oscillator is multiplied into each accepted sample. The oscillator turns at the negative of the programmed tuning frequency, so the selected channel lands at zero frequency and the real input becomes an I/Q pair.

Each rail then passes through a four-stage integrator-comb decimator. Its rate is chosen at runtime as D = 2^sel, and its gain is removed by an exact power-of-two shift. A fixed eight-tap symmetric lowpass follows. It keeps one result in four, lifts the passband to offset the comb droop, and rounds to the 16-bit output.

Software sets the tuning word and the rate through two strobed writes. The output rate is chosen as a small multiple of the symbol rate of the demodulator downstream.

Top module: `ddc_chain`

## Requirements
- R1: While reset is held and in the first cycles after it, out_valid is 0 and out_i and out_q are 0.
- R2: Counting accepted samples from reset or from the last rate write, out_valid pulses once per group of 4·D samples, where D = 2^dec_sel (codes above 6 are treated as 6). The pulse comes exactly 3 cycles after the clock edge that accepts the last sample of the group, and out_valid is never high at any other time.
- R3: With tuning word 0 and a constant input c, the settled outputs are out_i = 16·floor(c·32767/2^15) and out_q = 0, whatever the rate.
- R4: The oscillator is built as follows:
  - The 32-bit phase grows by the tuning word on every accepted sample.
  - Its top 6 bits pick one of 64 points on a full-scale-32767 sine/cosine, built from a quarter-wave table.
  - The mixer forms I = floor(x·cos/2^15) and Q = floor(−x·sin/2^15).
- R5: With tuning word 0x4000_0000, the input pattern c,0,−c,0 settles to out_i = 16·floor(m/2), where m = floor(c·32767/2^15), and out_q = 0.
- R6: With tuning word 0xC000_0000 (the negative quarter-rate), the pattern 0,c,0,−c settles to out_q = +16·floor(m/2). With 0x4000_0000 the same pattern gives out_q = 16·floor(floor(−c·32767/2^15)/2).
- R7: tune_word is loaded only in a cycle with tune_wr high; a changed tune_word without the strobe leaves the output unchanged.
- R8: A rate write clears the decimator and the filter state and restarts both phase counters. After a write, an all-zero input yields outputs that are exactly 0, and out_valid is low in the cycle after the write.
- R9: Cycles with in_valid low have no effect, whatever value in_data carries then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W (12) | Signed real input sample |
| tune_wr | input | 1 | Load strobe for tune_word |
| tune_word | input | PHASE_W (32) | Phase increment per sample |
| dec_wr | input | 1 | Load strobe for dec_sel; also clears the filter state |
| dec_sel | input | SEL_W (3) | Rate code, D = 2^dec_sel |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | OUT_W (16) | Signed in-phase output |
| out_q | output | OUT_W (16) | Signed quadrature output |

## Verification
Every output is due 3 cycles after the edge that accepts the last sample of its 4·D group, one register each in the mixer, the comb stage and the lowpass. The bench therefore records a due cycle for each group end as it drives samples, and at every falling edge it compares out_valid against that record, even with random idle gaps. Value checks use only the outputs after the sixth in a run, by which point the comb and lowpass transients have died out. Expected values come from the integer formulas in the requirements.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int LO_W      = 16;
  localparam int LO_AW     = 6;
  localparam int QN        = 1 << (LO_AW - 2);
  localparam int FIR_N     = 8;
  localparam int FIR_CW    = 8;
  localparam int FIR_SHIFT = 2;
  localparam int FIR_DEC   = 4;

  // first quadrant of a full-scale sine, QN+1 points
  function automatic logic signed [LO_W-1:0] quarter_sine(input int k);
    case (k)
      0:  return 16'sd0;
      1:  return 16'sd3212;
      2:  return 16'sd6393;
      3:  return 16'sd9512;
      4:  return 16'sd12539;
      5:  return 16'sd15446;
      6:  return 16'sd18204;
      7:  return 16'sd20787;
      8:  return 16'sd23170;
      9:  return 16'sd25329;
      10: return 16'sd27245;
      11: return 16'sd28898;
      12: return 16'sd30273;
      13: return 16'sd31356;
      14: return 16'sd32137;
      15: return 16'sd32609;
      default: return 16'sd32767;
    endcase
  endfunction

  // full-circle sine folded from the quarter table
  function automatic logic signed [LO_W-1:0] lo_sine(input logic [LO_AW-1:0] p);
    int i;
    i = int'(p[LO_AW-3:0]);
    case (p[LO_AW-1:LO_AW-2])
      2'd0:    return quarter_sine(i);
      2'd1:    return quarter_sine(QN - i);
      2'd2:    return -quarter_sine(i);
      default: return -quarter_sine(QN - i);
    endcase
  endfunction

  // symmetric droop-correcting lowpass, DC sum 64
  function automatic logic signed [FIR_CW-1:0] fir_coef(input int k);
    case (k)
      0, 7:    return -8'sd2;
      1, 6:    return -8'sd4;
      2, 5:    return 8'sd10;
      default: return 8'sd28;
    endcase
  endfunction
endpackage

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer
  import ddc_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int PHASE_W = 32,
  parameter int MIX_W   = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic signed [IN_W-1:0]    in_data,
  input  logic [PHASE_W-1:0]        step,
  output logic                      mix_valid,
  output logic signed [MIX_W-1:0]   mix_i,
  output logic signed [MIX_W-1:0]   mix_q
);
  localparam int PW = IN_W + LO_W;

  logic [PHASE_W-1:0]      phase;
  logic [LO_AW-1:0]        lo_idx;
  logic signed [LO_W-1:0]  lo_cos, lo_sin;
  logic signed [PW-1:0]    prod_i, prod_q;

  assign lo_idx = phase[PHASE_W-1 -: LO_AW];

  always_comb begin
    lo_sin = lo_sine(lo_idx);
    lo_cos = lo_sine(lo_idx + LO_AW'(QN));
    prod_i = PW'(in_data) * PW'(lo_cos);
    prod_q = -(PW'(in_data) * PW'(lo_sin));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      mix_valid <= 1'b0;
      mix_i     <= '0;
      mix_q     <= '0;
    end else begin
      mix_valid <= in_valid;
      if (in_valid) begin
        phase <= phase + step;
        mix_i <= MIX_W'(prod_i >>> (LO_W - 1));
        mix_q <= MIX_W'(prod_q >>> (LO_W - 1));
      end
    end
  end

  assert_idle_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));
endmodule

// File: rtl/ddc_cic_decim.sv
module ddc_cic_decim #(
  parameter int W_IN    = 13,
  parameter int N       = 4,
  parameter int SEL_W   = 3,
  parameter int SEL_MAX = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    in_v,
  input  logic signed [W_IN-1:0]  in_d,
  output logic                    out_v,
  output logic signed [W_IN-1:0]  out_d
);
  localparam int CW   = W_IN + N * SEL_MAX;
  localparam int SH_W = 8;

  logic signed [CW-1:0] integ [N];
  logic signed [CW-1:0] dly   [N];
  logic signed [CW-1:0] cch   [N+1];
  logic [SEL_MAX-1:0]   cnt, dmask;
  logic [SH_W-1:0]      shamt;
  logic                 tick;

  assign dmask = ~({SEL_MAX{1'b1}} << sel);
  assign tick  = (cnt == dmask);
  assign shamt = SH_W'(sel) * SH_W'(N);

  always_comb begin
    cch[0] = integ[N-1];
    for (int k = 0; k < N; k++) cch[k+1] = cch[k] - dly[k];
  end

  // integrators, registered in cascade, wrapping modulo 2^CW
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < N; k++) integ[k] <= '0;
    end else if (in_v) begin
      integ[0] <= integ[0] + CW'(in_d);
      for (int k = 1; k < N; k++) integ[k] <= integ[k] + integ[k-1];
    end
  end

  // rate counter and comb section
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      out_v <= 1'b0;
      out_d <= '0;
      for (int k = 0; k < N; k++) dly[k] <= '0;
    end else begin
      out_v <= 1'b0;
      if (in_v) begin
        if (tick) begin
          cnt   <= '0;
          out_v <= 1'b1;
          out_d <= W_IN'(cch[N] >>> shamt);
          for (int k = 0; k < N; k++) dly[k] <= cch[k];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_cic_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    out_v |-> $past(in_v));
  assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !out_v));
  assert_integrator_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_v && !clr) |=> $stable(integ[0]));
endmodule

// File: rtl/ddc_fir_decim4.sv
module ddc_fir_decim4
  import ddc_pkg::*;
#(
  parameter int W_IN  = 13,
  parameter int OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     in_v,
  input  logic signed [W_IN-1:0]   in_d,
  output logic                     out_v,
  output logic signed [OUT_W-1:0]  out_d
);
  localparam int TAPS  = FIR_N;
  localparam int HALF  = TAPS / 2;
  localparam int ACC_W = W_IN + 1 + FIR_CW + $clog2(HALF) + 1;
  localparam int PH_W  = $clog2(FIR_DEC);
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-(64'sd1 <<< (OUT_W - 1)));
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (FIR_SHIFT - 1));

  logic signed [W_IN-1:0]  hist [TAPS-1];
  logic signed [W_IN-1:0]  win  [TAPS];
  logic signed [ACC_W-1:0] acc, shv;
  logic [PH_W-1:0]         ph;

  always_comb begin
    logic signed [ACC_W-1:0] pre;
    win[0] = in_d;
    for (int k = 1; k < TAPS; k++) win[k] = hist[k-1];
    acc = '0;
    for (int k = 0; k < HALF; k++) begin
      pre = ACC_W'(win[k]) + ACC_W'(win[TAPS-1-k]);
      acc = acc + pre * ACC_W'(fir_coef(k));
    end
    shv = (acc + HALF_LSB) >>> FIR_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < TAPS-1; k++) hist[k] <= '0;
      ph    <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= 1'b0;
      if (in_v) begin
        hist[0] <= in_d;
        for (int k = 1; k < TAPS-1; k++) hist[k] <= hist[k-1];
        ph <= ph + 1'b1;
        if (ph == PH_W'(FIR_DEC - 1)) begin
          out_v <= 1'b1;
          if (shv > SMAX)      out_d <= SMAX[OUT_W-1:0];
          else if (shv < SMIN) out_d <= SMIN[OUT_W-1:0];
          else                 out_d <= shv[OUT_W-1:0];
        end
      end
    end
  end

  assert_output_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    out_v |=> !out_v);
  assert_fir_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_v |-> $past(in_v));
endmodule

// File: rtl/ddc_chain.sv
module ddc_chain #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 16,
  parameter int PHASE_W = 32,
  parameter int SEL_W   = 3,
  parameter int SEL_MAX = 6,
  parameter int SEL_RST = 2,
  parameter int CIC_N   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     tune_wr,
  input  logic [PHASE_W-1:0]       tune_word,
  input  logic                     dec_wr,
  input  logic [SEL_W-1:0]         dec_sel,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  localparam int MIX_W = IN_W + 1;

  logic [PHASE_W-1:0]      tw_q;
  logic [SEL_W-1:0]        sel_q;
  logic                    mix_v;
  logic signed [MIX_W-1:0] mix_d [2];
  logic                    cic_v [2];
  logic signed [MIX_W-1:0] cic_d [2];
  logic                    fir_v [2];
  logic signed [OUT_W-1:0] fir_d [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q  <= '0;
      sel_q <= SEL_W'(SEL_RST);
    end else begin
      if (tune_wr) tw_q <= tune_word;
      if (dec_wr)  sel_q <= (dec_sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : dec_sel;
    end
  end

  ddc_nco_mixer #(.IN_W(IN_W), .PHASE_W(PHASE_W), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .step(tw_q),
    .mix_valid(mix_v), .mix_i(mix_d[0]), .mix_q(mix_d[1])
  );

  for (genvar r = 0; r < 2; r++) begin : g_rail
    ddc_cic_decim #(.W_IN(MIX_W), .N(CIC_N), .SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_cic (
      .clk(clk), .rst(rst), .clr(dec_wr), .sel(sel_q),
      .in_v(mix_v), .in_d(mix_d[r]), .out_v(cic_v[r]), .out_d(cic_d[r])
    );
    ddc_fir_decim4 #(.W_IN(MIX_W), .OUT_W(OUT_W)) u_fir (
      .clk(clk), .rst(rst), .clr(dec_wr),
      .in_v(cic_v[r]), .in_d(cic_d[r]), .out_v(fir_v[r]), .out_d(fir_d[r])
    );
  end

  assign out_valid = fir_v[0];
  assign out_i     = fir_d[0];
  assign out_q     = fir_d[1];

  assert_rail_lockstep_R2: assert property (@(posedge clk) disable iff (rst)
    fir_v[0] == fir_v[1]);
  assert_write_flushes_output_R8: assert property (@(posedge clk) disable iff (rst)
    dec_wr |=> !out_valid);
  assert_tune_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !tune_wr |=> $stable(tw_q));
endmodule

// File: tb/ddc_chain_tb_top.sv
module ddc_chain_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        tune_wr = 1'b0;
  logic [31:0] tune_word = '0;
  logic        dec_wr = 1'b0;
  logic [2:0]  dec_sel = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  ddc_chain dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tune_wr(tune_wr), .tune_word(tune_word), .dec_wr(dec_wr), .dec_sel(dec_sel),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int cur_sel = 2;
  int grp = 0;
  bit due [int];
  int oi [$];
  int oq [$];
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: cadence monitor against the due record
  always @(negedge clk) begin
    bit exp_v;
    if (!rst) begin
      exp_v = due.exists(cyc);
      if (exp_v || out_valid) begin
        checks++;
        if (out_valid !== exp_v) begin
          fails++;
          $display("FAIL R2 cycle=%0d actual=%b expected=%b", cyc, out_valid, exp_v);
        end
      end
      if (out_valid) begin
        oi.push_back(int'($signed(out_i)));
        oq.push_back(int'($signed(out_q)));
      end
    end
  end

  function automatic int mix_pos(input int c);
    longint p;
    p = longint'(c) * 32767;
    return int'(p >>> 15);
  endfunction

  function automatic int mix_neg(input int c);
    longint p;
    p = -(longint'(c) * 32767);
    return int'(p >>> 15);
  endfunction

  function automatic int smp(input int mode, input int k, input int c);
    case (mode)
      0: return c;
      1: return (k % 4 == 0) ? c : ((k % 4 == 2) ? -c : 0);
      2: return (k % 4 == 1) ? c : ((k % 4 == 3) ? -c : 0);
      default: return int'($urandom_range(0, 4095)) - 2048;
    endcase
  endfunction

  task automatic feed(input int mode, input int c, input int n);
    int k;
    k = 0;
    while (k < n) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) begin
        in_valid = 1'b0;
        in_data  = 12'($urandom_range(0, 4095));
      end else begin
        in_valid = 1'b1;
        in_data  = 12'(smp(mode, k, c));
        if (grp % (4 << cur_sel) == (4 << cur_sel) - 1) due[cyc + 3] = 1'b1;
        grp++;
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_dec(input int s);
    @(negedge clk);
    dec_wr  = 1'b1;
    dec_sel = 3'(s);
    @(negedge clk);
    dec_wr  = 1'b0;
    cur_sel = s;
    grp     = 0;
    oi.delete();
    oq.delete();
  endtask

  task automatic set_tw(input logic [31:0] w);
    @(negedge clk);
    tune_wr   = 1'b1;
    tune_word = w;
    @(negedge clk);
    tune_wr   = 1'b0;
  endtask

  task automatic settled(input string ti, input int ei, input string tq, input int eq);
    check("R2 output count", oi.size(), 12);
    for (int j = 6; j < oi.size(); j++) begin
      check(ti, oi[j], ei);
      check(tq, oq[j], eq);
    end
  endtask

  task automatic dc_test(input int c, input int s, input string tag);
    set_dec(s);
    feed(0, c, 12 * (4 << s));
    settled({tag, " i"}, 16 * mix_pos(c), {tag, " q"}, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1: outputs idle while in reset
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 i in reset", int'($signed(out_i)), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 i after reset", int'($signed(out_i)), 0);
    check("R1 q after reset", int'($signed(out_q)), 0);

    // R3: unity-scaled DC across rates
    dc_test(1000, 2, "R3");
    dc_test(-2048, 0, "R3");
    dc_test(2047, 6, "R3");
    // R9: idle-cycle garbage ignored, checked on settled values
    dc_test(-37, 3, "R9");

    // R7: tune_word without strobe has no effect
    @(negedge clk);
    tune_word = 32'h4000_0000;
    dc_test(500, 1, "R7");

    // R5 / R4: quarter-rate tone brought to DC
    set_tw(32'h4000_0000);
    set_dec(2);
    feed(1, 1000, 12 * 16);
    settled("R5 i", 16 * (mix_pos(1000) >>> 1), "R5 q", 0);
    set_dec(2);
    feed(2, 1000, 12 * 16);
    settled("R4 i", 0, "R4 q", 16 * (mix_neg(1000) >>> 1));
    // R6: opposite tuning direction flips the quadrature sign
    set_tw(32'hC000_0000);
    set_dec(2);
    feed(2, 1000, 12 * 16);
    settled("R6 i", 0, "R6 q", 16 * (mix_pos(1000) >>> 1));
    set_tw(32'h0);

    // R8: rate write clears stored state
    set_dec(3);
    feed(0, 2000, 3 * 32 + 10);
    set_dec(3);
    feed(0, 0, 6 * 32);
    check("R8 count", oi.size(), 6);
    for (int j = 0; j < oi.size(); j++) begin
      check("R8 i zero", oi[j], 0);
      check("R8 q zero", oq[j], 0);
    end

    // R2: random data, several rates, partial groups cut by a write
    for (int t = 0; t < 5; t++) begin
      int s;
      s = (t == 4) ? 6 : int'($urandom_range(0, 5));
      set_dec(s);
      feed(3, 0, 4 * (4 << s) + (4 << s) / 2 + 1);
    end
    set_dec(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule